// File: doc/BRIEF.md
# Cache Configuration Search Sequencer

This block steers the search for a low energy-delay cache configuration when a new execution phase appears. On a start request it captures the most recently used cache configuration, a candidate budget and the energy-delay figure of the fixed base configuration. It then issues a sequence of candidate configurations, one at a time, and waits for an external energy-delay measurement after each one. It keeps the best configuration seen and reports it when the search ends.

Each candidate stands for one execution of the phase. The sequence first doubles cache size, then associativity, then line size, until every one of them is at its maximum. It then returns to the most recently used configuration and halves size, then associativity, then line size, until every one is at its minimum. The search stops when the budget of executions is used up or when no candidate is left. The block does not measure energy and does not reconfigure the cache. It handles one cache per run and stores no phase history.

Top module: `phase_cfg_tuner`

## Requirements
- R1: After reset, busy, apply_valid and done are all low.
- R2: Each parameter is carried as a 2-bit code. Size codes 0/1/2 mean 2/4/8 KB, associativity codes 0/1/2 mean 1/2/4 ways, and line codes 0/1/2 mean 16/32/64 bytes. Every issued or reported code stays within 0..2.
- R3: The first candidate of a run is the captured most recently used configuration.
- R4: Going upward, each candidate raises exactly one code by one. Size is raised to 2 first, then associativity, then line size.
- R5: Once all three codes have reached 2, the sequence restarts from the most recently used configuration. It then lowers size to 0, then associativity to 0, then line size to 0, one code step per candidate. A code that is already at its limit is skipped.
- R6: apply_valid stays high with a stable configuration until apply_ready is sampled high. The next candidate appears only after edp_valid arrives, and edp_valid outside that wait has no effect.
- R7: The best entry starts as the base configuration (codes 2,2,2) with base_edp. A measured value replaces it only when it is strictly lower, so an equal value keeps the older entry.
- R8: A run measures at most n_exec candidates and ends earlier if the sequence is exhausted. done is then high for one cycle with the best configuration and its EDP on the final outputs, and busy is low in the following cycle.
- R9: A start with n_exec equal to 0 issues no candidate. It reports the base configuration and base_edp.
- R10: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| n_exec | input | N_W | Budget of phase executions (candidates) |
| mru_size | input | 2 | Most recently used size code |
| mru_assoc | input | 2 | Most recently used associativity code |
| mru_line | input | 2 | Most recently used line code |
| base_edp | input | EDP_W | EDP of the base configuration |
| busy | output | 1 | Search in progress |
| apply_valid | output | 1 | Candidate configuration offered |
| apply_ready | input | 1 | Cache has taken the candidate |
| apply_size | output | 2 | Candidate size code |
| apply_assoc | output | 2 | Candidate associativity code |
| apply_line | output | 2 | Candidate line code |
| edp_valid | input | 1 | Measurement for the current candidate |
| edp_value | input | EDP_W | Unsigned measured EDP |
| done | output | 1 | One-cycle end-of-search pulse |
| final_size | output | 2 | Chosen size code |
| final_assoc | output | 2 | Chosen associativity code |
| final_line | output | 2 | Chosen line code |
| final_edp | output | EDP_W | EDP of the chosen configuration |

## Verification
The bench checks the candidate order for the starting points that matter most. From all minima no downward leg follows. From all maxima no upward leg exists. From a mixed point some codes are skipped in both legs. A design that reset the start point wrongly, or stepped two codes at once, would put a candidate out of order in the scoreboard. Truncation by a small budget and a zero budget are both covered; an off-by-one counter would issue one candidate too many or too few. A measurement equal to the stored best must not replace it, so a non-strict compare would report the wrong configuration. A stray measurement pulse of value 0 sent while a candidate is still unaccepted, a stalled handshake and a start sent in mid-run must all leave the run unchanged.

// File: rtl/pct_pkg.sv
package pct_pkg;
  parameter int CODE_W = 2;
  parameter int SZ_MAX = 2;
  parameter int AS_MAX = 2;
  parameter int LN_MAX = 2;
  localparam int NFIELD = 3;
  localparam int NSTAGE = 2 * NFIELD;

  typedef struct packed {
    logic [CODE_W-1:0] sz;
    logic [CODE_W-1:0] assoc;
    logic [CODE_W-1:0] ln;
  } tcfg_t;

  function automatic int field_max(input int f);
    case (f)
      0: return SZ_MAX;
      1: return AS_MAX;
      default: return LN_MAX;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] get_field(input tcfg_t c, input int f);
    case (f)
      0: return c.sz;
      1: return c.assoc;
      default: return c.ln;
    endcase
  endfunction

  function automatic tcfg_t set_field(input tcfg_t c, input int f,
                                      input logic [CODE_W-1:0] v);
    tcfg_t r;
    r = c;
    case (f)
      0: r.sz = v;
      1: r.assoc = v;
      default: r.ln = v;
    endcase
    return r;
  endfunction

  function automatic tcfg_t base_cfg();
    tcfg_t r;
    r.sz = CODE_W'(SZ_MAX);
    r.assoc = CODE_W'(AS_MAX);
    r.ln = CODE_W'(LN_MAX);
    return r;
  endfunction
endpackage

// File: rtl/pct_stepper.sv
module pct_stepper
  import pct_pkg::*;
(
  input  tcfg_t      cur,
  input  tcfg_t      mru,
  input  logic [2:0] stage,
  output logic       has_next,
  output tcfg_t      nxt,
  output logic [2:0] nxt_stage
);
  localparam int UPN = NFIELD;

  always_comb begin
    tcfg_t             start_pt;
    logic [CODE_W-1:0] v;
    has_next  = 1'b0;
    nxt       = cur;
    nxt_stage = stage;
    start_pt  = cur;
    v         = '0;
    for (int k = 0; k < NSTAGE; k++) begin
      if (!has_next && k >= int'(stage)) begin
        // the downward leg always departs from the remembered start point
        start_pt = (k >= UPN && int'(stage) < UPN) ? mru : cur;
        v = get_field(start_pt, k % NFIELD);
        if (k < UPN) begin
          if (int'(v) < field_max(k % NFIELD)) begin
            has_next  = 1'b1;
            nxt       = set_field(start_pt, k % NFIELD, v + 1'b1);
            nxt_stage = 3'(k);
          end
        end else if (v != '0) begin
          has_next  = 1'b1;
          nxt       = set_field(start_pt, k % NFIELD, v - 1'b1);
          nxt_stage = 3'(k);
        end
      end
    end
  end
endmodule

// File: rtl/pct_best.sv
module pct_best
  import pct_pkg::*;
#(
  parameter int EDP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [EDP_W-1:0] init_edp,
  input  logic             meas_valid,
  input  tcfg_t            meas_cfg,
  input  logic [EDP_W-1:0] meas_edp,
  output tcfg_t            best_cfg,
  output logic [EDP_W-1:0] best_edp
);
  tcfg_t            cfg_d;
  logic [EDP_W-1:0] edp_d;
  logic             en;

  always_comb begin
    en    = 1'b0;
    cfg_d = best_cfg;
    edp_d = best_edp;
    if (init) begin
      en    = 1'b1;
      cfg_d = base_cfg();
      edp_d = init_edp;
    end else if (meas_valid && (meas_edp < best_edp)) begin
      en    = 1'b1;
      cfg_d = meas_cfg;
      edp_d = meas_edp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_cfg <= base_cfg();
      best_edp <= '0;
    end else if (en) begin
      best_cfg <= cfg_d;
      best_edp <= edp_d;
    end
  end
endmodule

// File: rtl/phase_cfg_tuner.sv
module phase_cfg_tuner
  import pct_pkg::*;
#(
  parameter int N_W   = 4,
  parameter int EDP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_W-1:0]    n_exec,
  input  logic [CODE_W-1:0] mru_size,
  input  logic [CODE_W-1:0] mru_assoc,
  input  logic [CODE_W-1:0] mru_line,
  input  logic [EDP_W-1:0]  base_edp,
  output logic              busy,
  output logic              apply_valid,
  input  logic              apply_ready,
  output logic [CODE_W-1:0] apply_size,
  output logic [CODE_W-1:0] apply_assoc,
  output logic [CODE_W-1:0] apply_line,
  input  logic              edp_valid,
  input  logic [EDP_W-1:0]  edp_value,
  output logic              done,
  output logic [CODE_W-1:0] final_size,
  output logic [CODE_W-1:0] final_assoc,
  output logic [CODE_W-1:0] final_line,
  output logic [EDP_W-1:0]  final_edp
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} st_t;

  st_t            st, st_d;
  tcfg_t          cur, cur_d, mru_q, mru_in;
  logic [2:0]     stage, stage_d;
  logic [N_W-1:0] n_q, cnt, cnt_d, cnt_inc;
  logic           ld_start, ld_step, cnt_en, meas;
  logic           has_next;
  tcfg_t          nxt;
  logic [2:0]     nxt_stage;
  tcfg_t          best_cfg;

  assign mru_in  = '{sz: mru_size, assoc: mru_assoc, ln: mru_line};
  assign cnt_inc = cnt + 1'b1;

  pct_stepper u_step (
    .cur(cur), .mru(mru_q), .stage(stage),
    .has_next(has_next), .nxt(nxt), .nxt_stage(nxt_stage)
  );

  pct_best #(.EDP_W(EDP_W)) u_best (
    .clk(clk), .rst_n(rst_n),
    .init(ld_start), .init_edp(base_edp),
    .meas_valid(meas), .meas_cfg(cur), .meas_edp(edp_value),
    .best_cfg(best_cfg), .best_edp(final_edp)
  );

  always_comb begin
    st_d     = st;
    ld_start = 1'b0;
    ld_step  = 1'b0;
    cnt_en   = 1'b0;
    meas     = 1'b0;
    cur_d    = cur;
    stage_d  = stage;
    cnt_d    = cnt;
    case (st)
      S_IDLE: if (start) begin
        ld_start = 1'b1;
        cur_d    = mru_in;
        stage_d  = 3'd0;
        cnt_en   = 1'b1;
        cnt_d    = '0;
        st_d     = (n_exec == '0) ? S_FIN : S_ISSUE;
      end
      S_ISSUE: if (apply_ready) st_d = S_WAIT;
      S_WAIT: if (edp_valid) begin
        meas   = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_inc;
        if (cnt_inc == n_q || !has_next) begin
          st_d = S_FIN;
        end else begin
          ld_step = 1'b1;
          cur_d   = nxt;
          stage_d = nxt_stage;
          st_d    = S_ISSUE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mru_q <= '0;
      n_q   <= '0;
    end else if (ld_start) begin
      mru_q <= mru_in;
      n_q   <= n_exec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      stage <= '0;
    end else if (ld_start || ld_step) begin
      cur   <= cur_d;
      stage <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign busy        = (st != S_IDLE);
  assign apply_valid = (st == S_ISSUE);
  assign apply_size  = cur.sz;
  assign apply_assoc = cur.assoc;
  assign apply_line  = cur.ln;
  assign done        = (st == S_FIN);
  assign final_size  = best_cfg.sz;
  assign final_assoc = best_cfg.assoc;
  assign final_line  = best_cfg.ln;
endmodule

// File: rtl/pct_chk.sv
module pct_chk
  import pct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              apply_valid,
  input logic              apply_ready,
  input logic [CODE_W-1:0] apply_size,
  input logic [CODE_W-1:0] apply_assoc,
  input logic [CODE_W-1:0] apply_line,
  input logic              done,
  input logic [CODE_W-1:0] final_size,
  input logic [CODE_W-1:0] final_assoc,
  input logic [CODE_W-1:0] final_line
);
  // R6
  apply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid && !apply_ready |=> apply_valid && $stable(apply_size)
      && $stable(apply_assoc) && $stable(apply_line));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !apply_valid && !done);
  // R2
  apply_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid |-> int'(apply_size) <= SZ_MAX && int'(apply_assoc) <= AS_MAX
      && int'(apply_line) <= LN_MAX);
  // R2
  final_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(final_size) <= SZ_MAX && int'(final_assoc) <= AS_MAX
      && int'(final_line) <= LN_MAX);
endmodule

bind phase_cfg_tuner pct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .apply_valid(apply_valid), .apply_ready(apply_ready),
  .apply_size(apply_size), .apply_assoc(apply_assoc), .apply_line(apply_line),
  .done(done), .final_size(final_size), .final_assoc(final_assoc),
  .final_line(final_line)
);

// File: tb/phase_cfg_tuner_bench.sv
module phase_cfg_tuner_bench;
  import pct_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N_W = 4;
  localparam int EDP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_W-1:0] n_exec = '0;
  logic [1:0] mru_size = '0, mru_assoc = '0, mru_line = '0;
  logic [EDP_W-1:0] base_edp = '0;
  logic busy, apply_valid, done;
  logic apply_ready = 1'b0;
  logic [1:0] apply_size, apply_assoc, apply_line;
  logic edp_valid = 1'b0;
  logic [EDP_W-1:0] edp_value = '0;
  logic [1:0] final_size, final_assoc, final_line;
  logic [EDP_W-1:0] final_edp;

  int tests = 0, fails = 0;
  tcfg_t exp_q[$];
  int mode = 0, ridx = 0, cur_base = 1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_cfg_tuner #(.N_W(N_W), .EDP_W(EDP_W)) u_phase_cfg_tuner (
    .clk(clk), .rst_n(rst_n), .start(start), .n_exec(n_exec),
    .mru_size(mru_size), .mru_assoc(mru_assoc), .mru_line(mru_line),
    .base_edp(base_edp), .busy(busy), .apply_valid(apply_valid),
    .apply_ready(apply_ready), .apply_size(apply_size),
    .apply_assoc(apply_assoc), .apply_line(apply_line),
    .edp_valid(edp_valid), .edp_value(edp_value), .done(done),
    .final_size(final_size), .final_assoc(final_assoc),
    .final_line(final_line), .final_edp(final_edp)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int edp_of(input int m, input int i, input int b);
    case (m)
      0: return b - 10 * (i + 1);
      1: return b;
      default: return b + ((i * 7) % 5) - 2;
    endcase
  endfunction

  function automatic int pack3(input tcfg_t c);
    return int'(c.sz) * 100 + int'(c.assoc) * 10 + int'(c.ln);
  endfunction

  // monitor / responder: pops the scoreboard as candidates appear
  initial begin
    forever begin
      @(negedge clk);
      if (apply_valid && !apply_ready) begin
        tcfg_t seen, want;
        seen = '{sz: apply_size, assoc: apply_assoc, ln: apply_line};
        if (ridx % 2 == 1) begin
          // stall one cycle, with a stray measurement of 0 (R6)
          edp_valid = 1'b1;
          edp_value = '0;
          @(negedge clk);
          edp_valid = 1'b0;
          check("R6 held candidate", pack3('{sz: apply_size, assoc: apply_assoc,
                ln: apply_line}) + (apply_valid ? 0 : 1000), pack3(seen));
        end
        if (exp_q.size() == 0) begin
          check("R8 extra candidate", 1, 0);
          want = seen;
        end else begin
          want = exp_q.pop_front();
        end
        check("R3/R4/R5 candidate order", pack3(seen), pack3(want));
        apply_ready = 1'b1;
        @(negedge clk);
        apply_ready = 1'b0;
        @(negedge clk);
        edp_valid = 1'b1;
        edp_value = EDP_W'(edp_of(mode, ridx, cur_base));
        @(negedge clk);
        edp_valid = 1'b0;
        ridx++;
      end
    end
  end

  task automatic run_case(input int s, input int a, input int l, input int n,
                          input int b, input int m, input bit poke_start);
    tcfg_t c, mru, list[$], bc;
    int be, guard;
    mru = '{sz: 2'(s), assoc: 2'(a), ln: 2'(l)};
    c = mru; list.push_back(c);
    while (c.sz < 2) begin c.sz++; list.push_back(c); end
    while (c.assoc < 2) begin c.assoc++; list.push_back(c); end
    while (c.ln < 2) begin c.ln++; list.push_back(c); end
    c = mru;
    while (c.sz > 0) begin c.sz--; list.push_back(c); end
    while (c.assoc > 0) begin c.assoc--; list.push_back(c); end
    while (c.ln > 0) begin c.ln--; list.push_back(c); end
    bc = '{sz: 2'd2, assoc: 2'd2, ln: 2'd2};
    be = b;
    exp_q.delete();
    for (int i = 0; i < n && i < list.size(); i++) begin
      exp_q.push_back(list[i]);
      if (edp_of(m, i, b) < be) begin be = edp_of(m, i, b); bc = list[i]; end
    end
    mode = m; ridx = 0; cur_base = b;
    @(negedge clk);
    mru_size = 2'(s); mru_assoc = 2'(a); mru_line = 2'(l);
    n_exec = N_W'(n); base_edp = EDP_W'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (3) @(negedge clk);
      // R10: a start while busy must not restart or alter the run
      mru_size = 2'd0; mru_assoc = 2'd0; mru_line = 2'd0;
      n_exec = 4'd1; base_edp = 16'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check("R8 done reached", int'(done), 1);
    check("R7/R8 final configuration", pack3('{sz: final_size,
          assoc: final_assoc, ln: final_line}), pack3(bc));
    check("R7 final edp", int'(final_edp), be);
    check("R8 all candidates consumed", exp_q.size(), 0);
    @(negedge clk);
    check("R8 done single pulse", int'(done), 0);
    check("R8 busy released", int'(busy), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 apply_valid at reset", int'(apply_valid), 0);
    check("R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: zero budget gives the base configuration
    run_case(0, 1, 0, 0, 700, 0, 1'b0);
    // R4: from all minima, upward leg only, no downward leg
    run_case(0, 0, 0, 15, 1000, 0, 1'b0);
    // R5: from all maxima, downward leg only
    run_case(2, 2, 2, 15, 1000, 0, 1'b0);
    // R8: budget truncation
    run_case(1, 1, 1, 3, 1000, 0, 1'b0);
    // R5: mixed start with skipped codes, varied EDP, equal values (R7)
    run_case(1, 0, 2, 15, 1000, 2, 1'b0);
    // R7: all measurements equal to base, base must survive
    run_case(1, 1, 0, 15, 900, 1, 1'b0);
    // R10: start while busy
    run_case(0, 2, 1, 6, 1000, 2, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule